// File: doc/BRIEF.md
# Sticky Fault Cause Register

This block is a byte-wide status register for a power supervisor. It records which monitored source forced the system into reset. Three rail monitors and a qualified manual-reset source each feed one fault input. A fault input may be a one-cycle pulse or a level that lasts many cycles.

Every live bit of the register is active-low and sticky. A set bit is armed. When its source reports a failure, the bit drops to zero and stays there until the host writes a one to it again. After power-up the register holds all zeros, so it records nothing until software arms it. Writing 0x0D arms the three rail bits. Writing 0x0F also arms the manual-reset bit.

The host accesses the register over a plain single-register bus. A write strobe with a data byte loads the live bits at the clock edge. The read data is the register output itself, so it shows the contents as of the last clock edge. Reading therefore needs no strobe and has no side effects. No data is streamed through the block, so it has no valid/ready interface and no back-pressure.

Top module: `fault_cause_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register is loaded with 0x00, and `host_rd_data` reads 0x00 after that edge.
- R2: Each source has a fixed bit position. Rail inputs 0, 1 and 2 drive bits 0, 2 and 3. The manual-reset input drives bit 1. Bits 7 to 4 always read zero.
- R3: A source that is high during a cycle clears its bit at the next clock edge, whether the fault is a one-cycle pulse or a longer level.
- R4: A cleared bit stays cleared after its source goes low, and stays cleared until a host write sets it.
- R5: When `host_wr_en` is high at a clock edge, bits 3 to 0 load from `host_wr_data[3:0]`. A one arms a bit and a zero disarms it. `host_wr_data[7:4]` is ignored.
- R6: If a source is high in the same cycle as a host write of one to its bit, the fault wins and the bit ends up zero. This also holds when the fault persists across repeated writes.
- R7: With no write and no fault, the register holds its value across cycles. No bit ever rises from 0 to 1 without a write.
- R8: Writing 0x0D arms the three rail bits and leaves the manual-reset bit at zero. The register then reads 0x0D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe, one cycle per write |
| host_wr_data | input | 8 | Host write data |
| rail_fail | input | 3 | Per-rail fault indication, active high |
| mr_fail | input | 1 | Qualified manual-reset fault, active high |
| host_rd_data | output | 8 | Register contents as of the last clock edge |

## Verification
The assertions assume that the fault inputs and the write strobe are synchronous to `clk` and are settled at each rising edge. They do not assume that a fault is a single pulse, and they allow a fault and a write in the same cycle. The bench changes every input on the falling edge, so each input is stable for half a period around each rising edge. The bench covers single pulses, faults held over several cycles, and writes that collide with faults.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int REG_W   = 8;
  localparam int N_RAILS = 3;
  localparam int MR_POS  = 1;

  // Bit position for each rail monitor; the arming pattern 0x0D depends on it.
  function automatic int rail_pos(input int k);
    case (k)
      0:       return 0;
      1:       return 2;
      default: return 3;
    endcase
  endfunction

  // Set of bits that hold state; all others read zero.
  function automatic logic [REG_W-1:0] live_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < N_RAILS; k++) m[rail_pos(k)] = 1'b1;
    m[MR_POS] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fcr_src_map.sv
module fcr_src_map #(
  parameter int DATA_W = fcr_pkg::REG_W,
  parameter int N_RAIL = fcr_pkg::N_RAILS
) (
  input  logic [N_RAIL-1:0] rail_fail,
  input  logic              mr_fail,
  output logic [DATA_W-1:0] flt_vec
);
  always_comb begin
    flt_vec = '0;
    for (int k = 0; k < N_RAIL; k++) flt_vec[fcr_pkg::rail_pos(k)] = rail_fail[k];
    flt_vec[fcr_pkg::MR_POS] = mr_fail;
  end
endmodule

// File: rtl/fcr_cell.sv
module fcr_cell #(
  parameter bit LIVE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic fault,
  output logic q
);
  generate
    if (LIVE) begin : g_live
      logic state_q;
      always_ff @(posedge clk) begin
        if (!rst_n)     state_q <= 1'b0;
        else if (fault) state_q <= 1'b0;
        else if (wr_en) state_q <= wr_bit;
      end
      assign q = state_q;
    end else begin : g_dead
      logic unused;
      assign unused = clk ^ rst_n ^ wr_en ^ wr_bit ^ fault;
      assign q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fault_cause_reg.sv
module fault_cause_reg #(
  parameter int DATA_W = fcr_pkg::REG_W,
  parameter int N_RAIL = fcr_pkg::N_RAILS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic [N_RAIL-1:0] rail_fail,
  input  logic              mr_fail,
  output logic [DATA_W-1:0] host_rd_data
);
  localparam logic [DATA_W-1:0] LIVE_M = DATA_W'(fcr_pkg::live_mask());

  logic [DATA_W-1:0] flt_vec;

  fcr_src_map #(.DATA_W(DATA_W), .N_RAIL(N_RAIL)) u_map (
    .rail_fail (rail_fail),
    .mr_fail   (mr_fail),
    .flt_vec   (flt_vec)
  );

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      fcr_cell #(.LIVE(LIVE_M[i])) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (host_wr_en),
        .wr_bit (host_wr_data[i]),
        .fault  (flt_vec[i]),
        .q      (host_rd_data[i])
      );
    end
  endgenerate
endmodule

// File: rtl/fcr_chk.sv
module fcr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr_en,
  input logic [7:0] host_wr_data,
  input logic [2:0] rail_fail,
  input logic       mr_fail,
  input logic [7:0] host_rd_data
);
  logic [7:0] src;
  assign src = {4'b0000, rail_fail[2], rail_fail[1], mr_fail, rail_fail[0]};

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_data[7:4] == 4'h0);

  // R3
  fault_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src != 8'h00) |=> ((host_rd_data & $past(src)) == 8'h00));

  // R5
  write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && src == 8'h00) |=> (host_rd_data == ($past(host_wr_data) & 8'h0F)));

  // R6
  fault_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && src != 8'h00) |=>
      (host_rd_data == ($past(host_wr_data) & 8'h0F & ~$past(src))));

  // R7
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr_en |=> ((host_rd_data & ~$past(host_rd_data)) == 8'h00));

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr_en && src == 8'h00) |=> $stable(host_rd_data));
endmodule

bind fault_cause_reg fcr_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr_en   (host_wr_en),
  .host_wr_data (host_wr_data),
  .rail_fail    (rail_fail),
  .mr_fail      (mr_fail),
  .host_rd_data (host_rd_data)
);

// File: tb/sim_fault_cause_reg.sv
`timescale 1ns/1ps
module sim_fault_cause_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [2:0] rail = 3'b000;
  logic       mr = 1'b0;
  logic [7:0] rd;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fault_cause_reg u0 (
    .clk(clk), .rst_n(rst_n), .host_wr_en(we), .host_wr_data(wd),
    .rail_fail(rail), .mr_fail(mr), .host_rd_data(rd)
  );

  // Row layout: req[4], we, wd[8], rail[3], mr, exp[8]
  localparam int NV = 13;
  localparam logic [24:0] VEC [NV] = '{
    {4'd8, 1'b1, 8'h0D, 3'b000, 1'b0, 8'h0D},  // R8 arm rails
    {4'd7, 1'b0, 8'h00, 3'b000, 1'b0, 8'h0D},  // R7 idle hold
    {4'd3, 1'b0, 8'h00, 3'b001, 1'b0, 8'h0C},  // R3 rail0 -> bit0
    {4'd4, 1'b0, 8'h00, 3'b000, 1'b0, 8'h0C},  // R4 sticky
    {4'd5, 1'b1, 8'h0F, 3'b000, 1'b0, 8'h0F},  // R5 arm all
    {4'd2, 1'b0, 8'h00, 3'b000, 1'b1, 8'h0D},  // R2 manual -> bit1
    {4'd2, 1'b0, 8'h00, 3'b110, 1'b0, 8'h01},  // R2 rails1,2 -> bits2,3
    {4'd6, 1'b1, 8'hFF, 3'b100, 1'b0, 8'h07},  // R6 persistent fault beats write
    {4'd5, 1'b1, 8'h0F, 3'b000, 1'b0, 8'h0F},  // R5 re-arm
    {4'd6, 1'b1, 8'h0D, 3'b010, 1'b0, 8'h09},  // R6 collision on bit2
    {4'd5, 1'b1, 8'h00, 3'b000, 1'b0, 8'h00},  // R5 zero disarms
    {4'd3, 1'b0, 8'h00, 3'b001, 1'b0, 8'h00},  // R3 fault on cleared bit
    {4'd5, 1'b1, 8'hF0, 3'b000, 1'b0, 8'h00}   // R5 upper data ignored
  };

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (rd !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, rd, exp);
    end
  endtask

  // Apply inputs on the falling edge, then sample just after the next rising edge.
  task automatic step(input logic w, input logic [7:0] d, input logic [2:0] r, input logic m);
    @(negedge clk);
    we = w; wd = d; rail = r; mr = m;
    @(posedge clk);
    #1;
  endtask

  initial begin
    fork
      begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    join_none

    // R1 reset state
    step(1'b0, 8'h00, 3'b000, 1'b0);
    step(1'b0, 8'h00, 3'b000, 1'b0);
    check("R1", 8'h00);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][20], VEC[v][19:12], VEC[v][11:9], VEC[v][8]);
      n_chk++;
      if (rd !== VEC[v][7:0]) begin
        n_bad++;
        $display("FAIL R%0d row %0d: got %02h expected %02h",
                 VEC[v][24:21], v, rd, VEC[v][7:0]);
      end
    end

    // R3 fault held as a level: the bit stays cleared while the fault lasts
    step(1'b1, 8'h0F, 3'b000, 1'b0); check("R5", 8'h0F);
    step(1'b0, 8'h00, 3'b000, 1'b1); check("R3", 8'h0D);
    step(1'b0, 8'h00, 3'b000, 1'b1); check("R3", 8'h0D);
    // R6 writes while the manual fault persists cannot set bit 1
    step(1'b1, 8'h0F, 3'b000, 1'b1); check("R6", 8'h0D);
    step(1'b1, 8'h0F, 3'b000, 1'b0); check("R6", 8'h0F);

    // R7 idle cycles leave the value unchanged
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 8'hFF, 3'b000, 1'b0);
      check("R7", 8'h0F);
    end

    // R2 all sources together clear every live bit
    step(1'b0, 8'h00, 3'b111, 1'b1); check("R2", 8'h00);

    // R8 arm pattern keeps bit 1 at zero
    step(1'b1, 8'h0D, 3'b000, 1'b0); check("R8", 8'h0D);

    // R1 reset during operation, even with a write pending
    @(negedge clk); rst_n = 1'b0;
    step(1'b1, 8'h0F, 3'b000, 1'b0); check("R1", 8'h00);
    @(negedge clk); rst_n = 1'b1; we = 1'b0;
    step(1'b0, 8'h00, 3'b000, 1'b0); check("R1", 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule